// File: doc/BRIEF.md
# SMBus Host Controller Register Front End

This block is the software-facing register set of an SMBus host controller, reached through a byte-wide I/O window of 64 offsets. Software loads a slave address, a command byte, and up to two data bytes. For block transfers it also fills a 32-entry byte buffer, which is reached through one data offset whose index advances on every access. Software then writes the control register with the start bit set. The block checks the requested protocol. If the protocol is supported, it makes one request to a transaction engine, waits for that engine's completion, and stores any returned bytes. The serial engine sits outside the block. It reaches the block buffer through a port of its own.

A small state machine sequences each transaction. It has three states:

- `ST_IDLE`: nothing outstanding.
- `ST_ISSUE`: the request is held valid until the engine accepts it.
- `ST_WAIT`: the block waits for the engine's response.

Four transitions connect them:

- `T_START` (`ST_IDLE` to `ST_ISSUE`): a start with a supported code.
- `T_REJECT` (stays in `ST_IDLE`): a start with an unsupported code. This raises the error flag.
- `T_ACCEPT` (`ST_ISSUE` to `ST_WAIT`): the engine accepts the request.
- `T_DONE` (`ST_WAIT` to `ST_IDLE`): the engine responds, and the returned bytes are stored.

Top module: `smb_host_regs`

## Requirements
- R1: After reset every register reads 0: status, control, command, address, data0, data1 and the block byte at index 0. No request is pending.
- R2: Offsets 0x03 (command), 0x04 (address), 0x05 (data0) and 0x06 (data1) read back the last byte written. Offset 0x01 and all offsets from 0x08 to 0x3F read 0.
- R3: A read of offset 0x02 (control) returns only bits 4:0 of the stored control byte. The read also sets the block index to 0.
- R4: A write of any value to offset 0x00 (status) clears the error flag (status bit 2) and sets the block index to 0.
- R5: A control write with bit 6 set and protocol code (bits 4:2) equal to 0, 1, 2, 3 or 5 makes exactly one request. The request carries:
  - that protocol code;
  - the read flag, taken from address bit 0;
  - the 7-bit slave address, taken from address bits 7:1;
  - the command byte, data0 and data1.
- R6: A start with protocol code 4, 6 or 7 makes no request and sets status bit 2.
- R7: Status bit 0 reads 1 from the cycle after an accepted start until the engine responds. A control write while this bit is set is ignored: it makes no request and does not change the control register.
- R8: When a read transaction completes, the returned bytes are stored according to the protocol code:
  - codes 1 and 2 store the low byte into data0;
  - code 3 stores the low byte into data0 and the high byte into data1;
  - code 5 stores the byte count into data0.
  Quick commands and all write transactions leave data0 and data1 unchanged.
- R9: Each read or write of offset 0x07 accesses buffer[index] and then increments the index, which wraps from 31 to 0.
- R10: The engine reads and writes buffer entries through its own index port. Bytes written by the engine are seen by later host reads of offset 0x07, and the engine sees bytes the host has written.
- R11: A control write with bit 6 clear stores the byte and makes no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host byte write strobe |
| rd_en | input | 1 | Host byte read strobe (side effects at the clock edge) |
| addr | input | 6 | Offset within the I/O window |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, combinational while rd_en is high, else 0 |
| req_valid | output | 1 | Transaction request to the engine |
| req_ready | input | 1 | Engine accepts the request |
| req_proto | output | 3 | Protocol code |
| req_rd | output | 1 | 1 = read transaction |
| req_slave | output | 7 | Slave address |
| req_cmd | output | 8 | Command byte |
| req_d0 | output | 8 | data0 (block byte count for block writes) |
| req_d1 | output | 8 | data1 |
| rsp_valid | input | 1 | Engine completion pulse |
| rsp_lo | input | 8 | Returned low byte or block count |
| rsp_hi | input | 8 | Returned high byte |
| eng_idx | input | 5 | Engine buffer index |
| eng_we | input | 1 | Engine buffer write enable |
| eng_wdata | input | 8 | Engine buffer write data |
| eng_rdata | output | 8 | Buffer byte at eng_idx |

## Verification
The bench builds the block with its default parameters: a 32-entry buffer and a 64-offset window. At this size the whole buffer can be walked past its wrap point. The bench sweeps all eight protocol codes in both directions against an engine model, and derives every returned byte arithmetically from the request fields. The same sweep reaches the rejected codes, the ignored control write while busy, and both block directions through the engine's buffer port.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;

    localparam int WIN_AW = 6;

    localparam logic [WIN_AW-1:0] OFS_STS  = 6'h00;
    localparam logic [WIN_AW-1:0] OFS_CTL  = 6'h02;
    localparam logic [WIN_AW-1:0] OFS_CMD  = 6'h03;
    localparam logic [WIN_AW-1:0] OFS_ADR  = 6'h04;
    localparam logic [WIN_AW-1:0] OFS_D0   = 6'h05;
    localparam logic [WIN_AW-1:0] OFS_D1   = 6'h06;
    localparam logic [WIN_AW-1:0] OFS_BLK  = 6'h07;

    localparam int START_BIT = 6;

    localparam logic [2:0] PR_QUICK = 3'd0;
    localparam logic [2:0] PR_BYTE  = 3'd1;
    localparam logic [2:0] PR_BDATA = 3'd2;
    localparam logic [2:0] PR_WORD  = 3'd3;
    localparam logic [2:0] PR_BLOCK = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } smb_state_t;

    function automatic logic proto_ok(input logic [2:0] code);
        return (code == PR_QUICK) || (code == PR_BYTE) || (code == PR_BDATA) ||
               (code == PR_WORD)  || (code == PR_BLOCK);
    endfunction

endpackage

// File: rtl/smb_host_buf.sv
module smb_host_buf #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_clr,
    input  logic          host_step,
    input  logic          host_we,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic [IW-1:0] idx_o,
    input  logic [IW-1:0] eng_idx,
    input  logic          eng_we,
    input  logic [DW-1:0] eng_wdata,
    output logic [DW-1:0] eng_rdata
);

    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [IW-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (idx_clr) begin
            idx_q <= '0;
        end else if (host_step) begin
            idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cell
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem[g] <= '0;
                end else if (eng_we && eng_idx == IW'(g)) begin
                    mem[g] <= eng_wdata;
                end else if (host_we && idx_q == IW'(g)) begin
                    mem[g] <= host_wdata;
                end
            end
        end
    endgenerate

    assign host_rdata = mem[idx_q];
    assign eng_rdata  = mem[eng_idx];
    assign idx_o      = idx_q;

endmodule

// File: rtl/smb_host_ctl.sv
module smb_host_ctl
    import smb_host_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_ok,
    input  logic [2:0]    start_proto,
    input  logic [DW-1:0] addr_byte,
    input  logic [DW-1:0] cmd_byte,
    input  logic [DW-1:0] d0_byte,
    input  logic [DW-1:0] d1_byte,
    output logic          busy,
    output logic          req_valid,
    input  logic          req_ready,
    output logic [2:0]    req_proto,
    output logic          req_rd,
    output logic [DW-2:0] req_slave,
    output logic [DW-1:0] req_cmd,
    output logic [DW-1:0] req_d0,
    output logic [DW-1:0] req_d1,
    input  logic          rsp_valid,
    output logic          cap_lo_en,
    output logic          cap_hi_en
);

    smb_state_t state_q, state_d;
    logic [2:0]    proto_q;
    logic          rd_q;
    logic [DW-2:0] slave_q;
    logic [DW-1:0] cmd_q, d0_q, d1_q;

    // State register and request fields latched on T_START
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            proto_q <= '0;
            rd_q    <= 1'b0;
            slave_q <= '0;
            cmd_q   <= '0;
            d0_q    <= '0;
            d1_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_ok) begin
                proto_q <= start_proto;
                rd_q    <= addr_byte[0];
                slave_q <= addr_byte[DW-1:1];
                cmd_q   <= cmd_byte;
                d0_q    <= d0_byte;
                d1_q    <= d1_byte;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        req_valid = 1'b0;
        cap_lo_en = 1'b0;
        cap_hi_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok) state_d = ST_ISSUE;              // T_START
            end
            ST_ISSUE: begin
                req_valid = 1'b1;
                if (req_ready) state_d = ST_WAIT;              // T_ACCEPT
            end
            ST_WAIT: begin
                if (rsp_valid) begin                           // T_DONE
                    state_d   = ST_IDLE;
                    cap_lo_en = rd_q && (proto_q != PR_QUICK);
                    cap_hi_en = rd_q && (proto_q == PR_WORD);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign busy      = (state_q != ST_IDLE);
    assign req_proto = proto_q;
    assign req_rd    = rd_q;
    assign req_slave = slave_q;
    assign req_cmd   = cmd_q;
    assign req_d0    = d0_q;
    assign req_d1    = d1_q;

endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
    import smb_host_pkg::*;
#(
    parameter int BUF_DEPTH = 32,
    localparam int DW       = 8,
    localparam int IW       = $clog2(BUF_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [5:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          req_valid,
    input  logic          req_ready,
    output logic [2:0]    req_proto,
    output logic          req_rd,
    output logic [DW-2:0] req_slave,
    output logic [DW-1:0] req_cmd,
    output logic [DW-1:0] req_d0,
    output logic [DW-1:0] req_d1,
    input  logic          rsp_valid,
    input  logic [DW-1:0] rsp_lo,
    input  logic [DW-1:0] rsp_hi,
    input  logic [IW-1:0] eng_idx,
    input  logic          eng_we,
    input  logic [DW-1:0] eng_wdata,
    output logic [DW-1:0] eng_rdata
);

    logic [DW-1:0] ctl_q, cmd_q, adr_q, d0_q, d1_q;
    logic          err_q;
    logic          busy;
    logic          cap_lo_en, cap_hi_en;
    logic [DW-1:0] blk_rdata;
    logic [IW-1:0] blk_idx;

    logic       wr_ctl, start_req, start_ok, start_bad;
    logic [2:0] start_proto;

    assign wr_ctl      = wr_en && (addr == OFS_CTL) && !busy;
    assign start_proto = wdata[4:2];
    assign start_req   = wr_ctl && wdata[START_BIT];
    assign start_ok    = start_req && proto_ok(start_proto);
    assign start_bad   = start_req && !proto_ok(start_proto);   // T_REJECT

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            cmd_q <= '0;
            adr_q <= '0;
            d0_q  <= '0;
            d1_q  <= '0;
            err_q <= 1'b0;
        end else begin
            if (wr_ctl) ctl_q <= wdata;
            if (wr_en && addr == OFS_CMD) cmd_q <= wdata;
            if (wr_en && addr == OFS_ADR) adr_q <= wdata;
            if (cap_lo_en) d0_q <= rsp_lo;
            else if (wr_en && addr == OFS_D0) d0_q <= wdata;
            if (cap_hi_en) d1_q <= rsp_hi;
            else if (wr_en && addr == OFS_D1) d1_q <= wdata;
            if (wr_en && addr == OFS_STS) err_q <= 1'b0;
            else if (start_bad) err_q <= 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (addr)
                OFS_STS: rdata = {5'b0, err_q, 1'b0, busy};
                OFS_CTL: rdata = {3'b0, ctl_q[4:0]};
                OFS_CMD: rdata = cmd_q;
                OFS_ADR: rdata = adr_q;
                OFS_D0:  rdata = d0_q;
                OFS_D1:  rdata = d1_q;
                OFS_BLK: rdata = blk_rdata;
                default: rdata = '0;
            endcase
        end
    end

    smb_host_buf #(
        .DEPTH (BUF_DEPTH),
        .DW    (DW)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_clr    ((wr_en && addr == OFS_STS) || (rd_en && !wr_en && addr == OFS_CTL)),
        .host_step  ((wr_en || rd_en) && addr == OFS_BLK),
        .host_we    (wr_en && addr == OFS_BLK),
        .host_wdata (wdata),
        .host_rdata (blk_rdata),
        .idx_o      (blk_idx),
        .eng_idx    (eng_idx),
        .eng_we     (eng_we),
        .eng_wdata  (eng_wdata),
        .eng_rdata  (eng_rdata)
    );

    smb_host_ctl #(
        .DW (DW)
    ) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_ok    (start_ok),
        .start_proto (start_proto),
        .addr_byte   (adr_q),
        .cmd_byte    (cmd_q),
        .d0_byte     (d0_q),
        .d1_byte     (d1_q),
        .busy        (busy),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_proto   (req_proto),
        .req_rd      (req_rd),
        .req_slave   (req_slave),
        .req_cmd     (req_cmd),
        .req_d0      (req_d0),
        .req_d1      (req_d1),
        .rsp_valid   (rsp_valid),
        .cap_lo_en   (cap_lo_en),
        .cap_hi_en   (cap_hi_en)
    );

endmodule

// File: rtl/smb_host_chk.sv
module smb_host_chk #(
    parameter int BUF_DEPTH = 32,
    localparam int IW = $clog2(BUF_DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic [5:0]    addr,
    input logic          req_valid,
    input logic          req_ready,
    input logic [2:0]    req_proto,
    input logic [6:0]    req_slave,
    input logic [7:0]    req_cmd,
    input logic          busy,
    input logic          err_q,
    input logic [IW-1:0] blk_idx
);

    a_r7_idle_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid);

    a_r5_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=>
            (req_valid && $stable(req_proto) && $stable(req_slave) && $stable(req_cmd)));

    a_r6_bad_code_never_issued: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_proto != 3'd4 && req_proto != 3'd6 && req_proto != 3'd7));

    a_r4_status_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 6'h00) |=> (!err_q && blk_idx == '0));

    a_r3_ctl_read_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == 6'h02) |=> (blk_idx == '0));

    a_r9_index_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && addr == 6'h07 && blk_idx == IW'(BUF_DEPTH - 1)) |=> (blk_idx == '0));

endmodule

bind smb_host_regs smb_host_chk #(.BUF_DEPTH(BUF_DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_proto (req_proto),
    .req_slave (req_slave),
    .req_cmd   (req_cmd),
    .busy      (busy),
    .err_q     (err_q),
    .blk_idx   (blk_idx)
);

// File: tb/sim_smb_host_regs.sv
`timescale 1ns/1ps
module sim_smb_host_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic       req_valid, req_ready = 1'b0, req_rd;
    logic [2:0] req_proto;
    logic [6:0] req_slave;
    logic [7:0] req_cmd, req_d0, req_d1;
    logic       rsp_valid = 1'b0;
    logic [7:0] rsp_lo = '0, rsp_hi = '0;
    logic [4:0] eng_idx = '0;
    logic       eng_we = 1'b0;
    logic [7:0] eng_wdata = '0, eng_rdata;

    int checks = 0, errors = 0;
    int req_cnt = 0;
    logic [2:0] e_proto;
    logic       e_rd;
    logic [6:0] e_slave;
    logic [7:0] e_cmd, e_d0, e_d1;
    logic [7:0] blkw [8];

    always #2 clk = ~clk;

    smb_host_regs u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_proto(req_proto), .req_rd(req_rd), .req_slave(req_slave), .req_cmd(req_cmd),
        .req_d0(req_d0), .req_d1(req_d1), .rsp_valid(rsp_valid), .rsp_lo(rsp_lo),
        .rsp_hi(rsp_hi), .eng_idx(eng_idx), .eng_we(eng_we), .eng_wdata(eng_wdata),
        .eng_rdata(eng_rdata)
    );

    function automatic logic [7:0] resp_low(input logic [6:0] s, input logic [7:0] c);
        return c ^ 8'h5A ^ {1'b0, s};
    endfunction

    // Engine model
    initial begin
        forever begin
            @(negedge clk);
            if (req_valid) begin
                e_proto = req_proto; e_rd = req_rd; e_slave = req_slave;
                e_cmd = req_cmd; e_d0 = req_d0; e_d1 = req_d1;
                req_cnt++;
                repeat (2) @(negedge clk);
                req_ready = 1'b1;
                @(negedge clk);
                req_ready = 1'b0;
                if (e_proto == 3'd5 && e_rd) begin
                    for (int j = 0; j < 4; j++) begin
                        eng_we = 1'b1; eng_idx = 5'(j); eng_wdata = 8'hC0 + 8'(j);
                        @(negedge clk);
                    end
                    eng_we = 1'b0;
                end
                if (e_proto == 3'd5 && !e_rd) begin
                    for (int j = 0; j < int'(e_d0) && j < 8; j++) begin
                        eng_idx = 5'(j);
                        #1 blkw[j] = eng_rdata;
                        @(negedge clk);
                    end
                end
                rsp_lo = (e_proto == 3'd5) ? 8'd4 : resp_low(e_slave, e_cmd);
                rsp_hi = ~resp_low(e_slave, e_cmd);
                rsp_valid = 1'b1;
                @(negedge clk);
                rsp_valid = 1'b0;
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic run_case(input int p, input int rw);
        logic [7:0] v, d0, d1, cmd;
        logic [6:0] sl;
        int n0, k;
        bit ok;
        ok  = (p == 0 || p == 1 || p == 2 || p == 3 || p == 5);
        sl  = 7'h20 + 7'(p);
        cmd = 8'h40 + 8'(p * 2 + rw);
        d0  = (p == 5 && rw == 0) ? 8'd3 : 8'h10 + 8'(p);
        d1  = 8'h80 + 8'(p);
        wr(6'h00, 8'hFF);
        wr(6'h04, {sl, 1'(rw)});
        wr(6'h03, cmd);
        wr(6'h05, d0);
        wr(6'h06, d1);
        if (p == 5 && rw == 0)
            for (int j = 0; j < 3; j++) wr(6'h07, 8'hE0 + 8'(j));
        n0 = req_cnt;
        wr(6'h02, 8'h40 | 8'(p << 2));
        if (ok) begin
            rd(6'h00, v);
            chk($sformatf("R7 busy after start p%0d", p), v & 8'h01, 8'h01);
            wr(6'h02, 8'h40 | 8'(3 << 2));   // R7: ignored while busy
            k = 0;
            do begin rd(6'h00, v); k++; end while (v[0] && k < 60);
            chk("R7 busy cleared", v, 8'h00);
            chk($sformatf("R5 one request p%0d rw%0d", p, rw), 8'(req_cnt - n0), 8'd1);
            chk("R5 proto", {5'b0, e_proto}, 8'(p));
            chk("R5 read flag", {7'b0, e_rd}, 8'(rw));
            chk("R5 slave", {1'b0, e_slave}, {1'b0, sl});
            chk("R5 cmd", e_cmd, cmd);
            chk("R5 d0", e_d0, d0);
            chk("R5 d1", e_d1, d1);
            rd(6'h02, v);
            chk("R7 ctl unchanged by busy write", v, 8'(p << 2));
            rd(6'h05, v);
            if (rw == 1 && p == 5)      chk("R8 block count", v, 8'd4);
            else if (rw == 1 && p != 0) chk("R8 data0 low", v, resp_low(sl, cmd));
            else                        chk("R8 data0 kept", v, d0);
            rd(6'h06, v);
            if (rw == 1 && p == 3) chk("R8 data1 high", v, ~resp_low(sl, cmd));
            else                   chk("R8 data1 kept", v, d1);
            if (p == 5 && rw == 1) begin
                wr(6'h00, 8'h00);
                for (int j = 0; j < 4; j++) begin
                    rd(6'h07, v);
                    chk("R10 engine bytes", v, 8'hC0 + 8'(j));
                end
            end
            if (p == 5 && rw == 0)
                for (int j = 0; j < 3; j++) chk("R10 engine sees host bytes", blkw[j], 8'hE0 + 8'(j));
        end else begin
            repeat (6) @(negedge clk);
            rd(6'h00, v);
            chk($sformatf("R6 error bit p%0d", p), v, 8'h04);
            chk("R6 no request", 8'(req_cnt - n0), 8'd0);
            wr(6'h00, 8'h5C);
            rd(6'h00, v);
            chk("R4 error cleared", v, 8'h00);
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic [7:0] pats [4];
        int n0;
        pats[0] = 8'h00; pats[1] = 8'h5A; pats[2] = 8'hA5; pats[3] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(6'(a), v);
            chk($sformatf("R1 reset offset %0d", a), v, 8'h00);
        end
        chk("R1 no request", {7'b0, req_valid}, 8'h00);

        // R2 readback sweep
        for (int a = 3; a <= 6; a++)
            for (int i = 0; i < 4; i++) begin
                wr(6'(a), pats[i]);
                rd(6'(a), v);
                chk($sformatf("R2 readback offset %0d", a), v, pats[i]);
            end
        for (int a = 8; a < 64; a += 5) begin
            wr(6'(a), 8'hFF);
            rd(6'(a), v);
            chk("R2 unmapped reads 0", v, 8'h00);
        end
        rd(6'h01, v);
        chk("R2 offset 1 reads 0", v, 8'h00);

        // R9 buffer wrap: 40 writes, indices 0..7 overwritten
        wr(6'h00, 8'h00);
        for (int i = 0; i < 40; i++) wr(6'h07, 8'(i * 7 + 3));
        wr(6'h00, 8'h00);   // R4 index reset
        for (int k = 0; k < 33; k++) begin
            int kk;
            kk = k % 32;
            rd(6'h07, v);
            chk("R9 buffer walk", v, (kk < 8) ? 8'((kk + 32) * 7 + 3) : 8'(kk * 7 + 3));
        end

        // R11 and R3
        n0 = req_cnt;
        wr(6'h02, 8'h9F);
        repeat (6) @(negedge clk);
        chk("R11 no request", 8'(req_cnt - n0), 8'd0);
        rd(6'h02, v);
        chk("R3 control low bits", v, 8'h1F);
        rd(6'h07, v); rd(6'h07, v);
        rd(6'h02, v);
        rd(6'h07, v);
        chk("R3 read rewinds index", v, 8'(32 * 7 + 3));

        // R5..R8 protocol sweep
        for (int p = 0; p < 8; p++)
            for (int rw = 0; rw < 2; rw++)
                run_case(p, rw);

        finish_run();
    end

endmodule